// File: doc/BRIEF.md
# SCL Timing Generator

This block sets the bus clock timing for an I2C master engine. It runs from the system clock and tells the engine, cycle by cycle, when to hold SCL low and when to release it. It also marks the cycle in which to drive the next SDA bit and the cycle in which to sample SDA. The engine's control word and address word arrive as two 32-bit inputs. The block decodes its divider fields from them and ignores every other bit.

There are two timing modes. In split mode the low phase and the high phase have their own 12-bit counts. The high phase also carries a fixed 15-clock latency, which stands for the input filter delay. In symmetric mode a single 12-bit divider sets both phases to the same length, so the count is one quarter of the SCL period. The divider values are captured only while the engine is idle (`run_i` low), so writing new values during a transfer cannot change the timing of that transfer. Software works out the counts from the wanted bus frequency.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and before `run_i` has been seen high, `scl_low_o` and all four strobes are 0.
- R2: When the edge that first samples `run_i` high comes after an idle cycle, the next cycle is the first low-phase cycle: `scl_low_o` is 1 and the low phase begins.
- R3: In split mode (address word bit 28 set), each low phase lasts the low count plus one clocks. The low count is address word bits [27:16].
- R4: In split mode, each high phase lasts the divider plus 15 clocks. Divider bits [9:0] are control word bits [21:12] and divider bits [11:10] are control word bits [29:28].
- R5: In symmetric mode (address word bit 28 clear), both phases last twice the divider, a divider of zero counts as one, and the low count field has no effect.
- R6: `sda_launch_o` pulses once per low phase, at offset floor(L/2) from its first cycle, where L is the low-phase length.
- R7: `sda_sample_o` pulses once per high phase, at offset floor(H/2) from its first cycle, where H is the high-phase length.
- R8: `scl_fall_o` pulses in the first cycle of every low phase and `scl_rise_o` pulses in the first cycle of every high phase.
- R9: The cycle after an edge that samples `run_i` low, SCL is released and no strobe is active.
- R10: The divider fields are captured only on edges where `run_i` is low. Changing them while `run_i` is high has no effect on the running pattern.
- R11: The filter fields (address bits [13:8]), the address byte and every other bit outside the divider fields have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Engine busy; high keeps SCL toggling, low idles and captures the dividers |
| ctrl_reg_i | input | 32 | Control word holding the divider fields |
| addr_reg_i | input | 32 | Address word holding the low count and split enable |
| scl_low_o | output | 1 | 1 while SCL must be driven low |
| scl_fall_o | output | 1 | Pulse in the first cycle of each low phase |
| scl_rise_o | output | 1 | Pulse in the first cycle of each high phase |
| sda_launch_o | output | 1 | Pulse at mid low phase: drive next SDA bit |
| sda_sample_o | output | 1 | Pulse at mid high phase: sample SDA |

## Verification
The assertions check on every cycle that the phase counter stays below the captured length of the current phase. They also check that idling releases SCL at once, that a start always enters the low phase at offset zero, that launch and sample strobes fall in the right phase, and that the captured lengths hold still while running. Only the bench scenarios can show that the phase lengths match the decoded fields and the filter latency, including the split of the divider across two fields. The same holds for the midpoint offsets, for symmetric-mode doubling with its zero case, and for the fact that unrelated bits and writes made during a run change nothing.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;
  // field positions decoded from the engine's register words
  localparam int CTRL_DIV_LSB     = 12;
  localparam int CTRL_DIV_LO_W    = 10;
  localparam int CTRL_DIV_EXT_LSB = 28;
  localparam int ADDR_LOW_LSB     = 16;
  localparam int ADDR_SPLIT_BIT   = 28;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_cfg_latch.sv
`timescale 1ns/1ps
module scl_cfg_latch
  import scl_div_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int FILTER_LAT = 15,
  parameter int REG_W      = 32,
  parameter int LEN_W      = DIV_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [REG_W-1:0] ctrl_i,
  input  logic [REG_W-1:0] addr_i,
  output logic [LEN_W-1:0] lo_len_o,
  output logic [LEN_W-1:0] hi_len_o
);
  localparam int EXT_W = DIV_W - CTRL_DIV_LO_W;

  logic             unused_regs;
  logic [DIV_W-1:0] div_w, lo_cnt_w, sym_w;
  logic             split_w;
  logic [LEN_W-1:0] sym_len_w, lo_next, hi_next;

  assign unused_regs = ^{ctrl_i, addr_i};

  assign div_w    = {ctrl_i[CTRL_DIV_EXT_LSB +: EXT_W], ctrl_i[CTRL_DIV_LSB +: CTRL_DIV_LO_W]};
  assign lo_cnt_w = addr_i[ADDR_LOW_LSB +: DIV_W];
  assign split_w  = addr_i[ADDR_SPLIT_BIT];

  // symmetric divider: period = 4*div, each phase 2*div, zero clamps to one
  assign sym_w     = (div_w == '0) ? DIV_W'(1) : div_w;
  assign sym_len_w = LEN_W'(sym_w) << 1;

  always_comb begin
    if (split_w) begin
      lo_next = LEN_W'(lo_cnt_w) + LEN_W'(1);
      hi_next = LEN_W'(div_w) + LEN_W'(FILTER_LAT);
    end else begin
      lo_next = sym_len_w;
      hi_next = sym_len_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_len_o <= LEN_W'(2);
      hi_len_o <= LEN_W'(2);
    end else if (!run_i) begin
      lo_len_o <= lo_next;
      hi_len_o <= hi_next;
    end
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($stable(lo_len_o) && $stable(hi_len_o)));
endmodule

// File: rtl/scl_phase_timer.sv
`timescale 1ns/1ps
module scl_phase_timer
  import scl_div_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LEN_W-1:0] lo_len_i,
  input  logic [LEN_W-1:0] hi_len_i,
  output phase_e           phase_o,
  output logic [LEN_W-1:0] cnt_o
);
  logic lo_end, hi_end;
  assign lo_end = (cnt_o == lo_len_i - LEN_W'(1));
  assign hi_end = (cnt_o == hi_len_i - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_IDLE;
      cnt_o   <= '0;
    end else if (!run_i) begin
      phase_o <= PH_IDLE;
      cnt_o   <= '0;
    end else begin
      unique case (phase_o)
        PH_LOW: begin
          if (lo_end) begin
            phase_o <= PH_HIGH;
            cnt_o   <= '0;
          end else begin
            cnt_o <= cnt_o + LEN_W'(1);
          end
        end
        PH_HIGH: begin
          if (hi_end) begin
            phase_o <= PH_LOW;
            cnt_o   <= '0;
          end else begin
            cnt_o <= cnt_o + LEN_W'(1);
          end
        end
        default: begin
          phase_o <= PH_LOW;
          cnt_o   <= '0;
        end
      endcase
    end
  end

  // R3
  lo_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_LOW) |-> (cnt_o < lo_len_i));
  // R4
  hi_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_HIGH) |-> (cnt_o < hi_len_i));
  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_IDLE && run_i) |=> (phase_o == PH_LOW && cnt_o == '0));
  // R9
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (phase_o == PH_IDLE));
endmodule

// File: rtl/scl_strobe_gen.sv
`timescale 1ns/1ps
module scl_strobe_gen
  import scl_div_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] lo_len_i,
  input  logic [LEN_W-1:0] hi_len_i,
  output logic             scl_low_o,
  output logic             scl_fall_o,
  output logic             scl_rise_o,
  output logic             sda_launch_o,
  output logic             sda_sample_o
);
  logic [1:0] mid_hit;
  logic       at_zero;

  // g=0: low phase midpoint, g=1: high phase midpoint
  for (genvar g = 0; g < 2; g++) begin : g_mid
    phase_e           ph;
    logic [LEN_W-1:0] len;
    assign ph  = (g == 0) ? PH_LOW : PH_HIGH;
    assign len = (g == 0) ? lo_len_i : hi_len_i;
    assign mid_hit[g] = (phase_i == ph) && (cnt_i == (len >> 1));
  end

  assign at_zero      = (cnt_i == '0);
  assign scl_low_o    = (phase_i == PH_LOW);
  assign scl_fall_o   = (phase_i == PH_LOW) && at_zero;
  assign scl_rise_o   = (phase_i == PH_HIGH) && at_zero;
  assign sda_launch_o = mid_hit[0];
  assign sda_sample_o = mid_hit[1];

  // R6
  launch_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_launch_o |-> scl_low_o);
  // R7
  sample_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_sample_o |-> (!scl_low_o && phase_i != PH_IDLE));
  // R8
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_fall_o, scl_rise_o}));
endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import scl_div_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int FILTER_LAT = 15,
  parameter int REG_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [REG_W-1:0] ctrl_reg_i,
  input  logic [REG_W-1:0] addr_reg_i,
  output logic             scl_low_o,
  output logic             scl_fall_o,
  output logic             scl_rise_o,
  output logic             sda_launch_o,
  output logic             sda_sample_o
);
  localparam int LEN_W = DIV_W + 2;

  logic [LEN_W-1:0] lo_len, hi_len, cnt;
  phase_e           phase;

  scl_cfg_latch #(
    .DIV_W(DIV_W), .FILTER_LAT(FILTER_LAT), .REG_W(REG_W), .LEN_W(LEN_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .ctrl_i(ctrl_reg_i), .addr_i(addr_reg_i),
    .lo_len_o(lo_len), .hi_len_o(hi_len)
  );

  scl_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .lo_len_i(lo_len), .hi_len_i(hi_len),
    .phase_o(phase), .cnt_o(cnt)
  );

  scl_strobe_gen #(.LEN_W(LEN_W)) u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .phase_i(phase), .cnt_i(cnt), .lo_len_i(lo_len), .hi_len_i(hi_len),
    .scl_low_o(scl_low_o), .scl_fall_o(scl_fall_o), .scl_rise_o(scl_rise_o),
    .sda_launch_o(sda_launch_o), .sda_sample_o(sda_sample_o)
  );
endmodule

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        run = 0;
  logic [31:0] ctrl = 0, addr = 0;
  logic        scl_low, fall, rise, launch, sample;
  int          checks = 0, fails = 0;
  int          cyc = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  scl_timing_gen u_scl_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .ctrl_reg_i(ctrl), .addr_reg_i(addr),
    .scl_low_o(scl_low), .scl_fall_o(fall), .scl_rise_o(rise),
    .sda_launch_o(launch), .sda_sample_o(sample)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk_ctrl(int div, logic [31:0] noise);
    logic [11:0] d = 12'(div);
    return (noise & ~32'h303F_F000) | ({30'd0, d[11:10]} << 28) | ({22'd0, d[9:0]} << 12);
  endfunction

  function automatic logic [31:0] mk_addr(int lo, bit split, logic [31:0] noise);
    logic [11:0] l = 12'(lo);
    return (noise & ~32'h1FFF_0000) | ({20'd0, l} << 16) | ({31'd0, split} << 28);
  endfunction

  function automatic int exp_lo(bit split, int lo, int div);
    return split ? lo + 1 : 2 * ((div == 0) ? 1 : div);
  endfunction

  function automatic int exp_hi(bit split, int div);
    return split ? div + 15 : 2 * ((div == 0) ? 1 : div);
  endfunction

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // program while idle, run for n periods, compare every cycle, then idle
  task automatic run_case(string req_len, bit split, int lo, int div,
                          logic [31:0] cn, logic [31:0] an, int periods,
                          bit change, logic [31:0] c2, logic [31:0] a2);
    int L = exp_lo(split, lo, div);
    int H = exp_hi(split, div);
    int P = L + H;
    int e_low = 0, e_edge = 0, e_launch = 0, e_sample = 0;
    @(negedge clk);
    run  = 0;
    ctrl = mk_ctrl(div, cn);
    addr = mk_addr(lo, split, an);
    @(negedge clk);
    run = 1;
    for (int i = 0; i < P * periods; i++) begin
      int p;
      @(negedge clk);
      p = i % P;
      if (scl_low != (p < L)) e_low++;
      if (fall != (p == 0) || rise != (p == L)) e_edge++;
      if (launch != (p == L / 2)) e_launch++;
      if (sample != (p == L + H / 2)) e_sample++;
      if (change && i == 1) begin
        ctrl = c2;
        addr = a2;
      end
    end
    run = 0;
    check(req_len, "scl_low pattern mismatches", e_low, 0);
    check("R8", "fall/rise tick mismatches", e_edge, 0);
    check("R6", "launch strobe mismatches", e_launch, 0);
    check("R7", "sample strobe mismatches", e_sample, 0);
    @(negedge clk);
    check("R9", "outputs after idle", {scl_low, fall, rise, launch, sample}, 0);
  endtask

  initial begin
    int seed = 32'h5C1D_0042;
    void'($urandom(seed));
    #1;
    check("R1", "outputs in reset", {scl_low, fall, rise, launch, sample}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1", "outputs after reset", {scl_low, fall, rise, launch, sample}, 0);

    // R2: first cycle after start is low (covered by pattern index 0)
    run_case("R2", 1, 3, 4, 0, 0, 2, 0, 0, 0);
    // R3/R4 minimum: L=1, H=15
    run_case("R3", 1, 0, 0, 0, 0, 3, 0, 0, 0);
    // R4 divider carried only in the extension field
    run_case("R4", 1, 2, 12'h400, 0, 0, 1, 0, 0, 0);
    run_case("R4", 1, 5, 12'h3FF, 0, 0, 1, 0, 0, 0);
    // maximum split counts
    run_case("R3", 1, 4095, 4095, 0, 0, 1, 0, 0, 0);
    // R5: zero divider clamps, low field ignored
    run_case("R5", 0, 0, 0, 0, 0, 3, 0, 0, 0);
    run_case("R5", 0, 4095, 7, 0, 0, 2, 0, 0, 0);
    run_case("R5", 0, 0, 12'h401, 0, 0, 1, 0, 0, 0);
    // R10: rewrite fields mid-run, old pattern continues
    run_case("R10", 1, 6, 9, 0, 0, 3, 1,
             mk_ctrl(200, 0), mk_addr(1, 0, 0));
    run_case("R10", 0, 0, 5, 0, 0, 3, 1,
             mk_ctrl(1, 0), mk_addr(30, 1, 0));
    // R11: filter fields, address byte and other bits all set
    run_case("R11", 1, 7, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 0, 0, 0);
    run_case("R11", 0, 9, 6, 32'hC00F_0FFF, 32'h0000_3FFF, 2, 0, 0, 0);

    for (int k = 0; k < 20; k++) begin
      bit split = 1'($urandom);
      int lo = $urandom_range(0, 40);
      int dv = $urandom_range(0, 40);
      run_case(split ? "R3" : "R5", split, lo, dv, $urandom, $urandom, 2, 0, 0, 0);
    end

    // R9: drop run in the middle of a high phase
    @(negedge clk);
    ctrl = mk_ctrl(20, 0); addr = mk_addr(3, 1, 0);
    @(negedge clk);
    run = 1;
    repeat (10) @(negedge clk);
    check("R9", "scl released mid high before drop", scl_low, 0);
    run = 0;
    @(negedge clk);
    check("R9", "outputs one cycle after drop", {scl_low, fall, rise, launch, sample}, 0);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule